// File: doc/BRIEF.md
# Mixed-Access Status Register with Event Latching

This block is one 16-bit register of a transceiver's management space. Each bit position gets its own access behaviour at build time from a packed parameter of 3-bit kind codes. Plain kinds cover bits that follow a live signal, bits that software only writes, ordinary stored bits, and stored bits that drop back to zero by themselves. Event kinds keep short status glitches visible until software looks: a low pulse, a high pulse, or any edge on the live input is held in the register until the next read.

A read is a one-cycle strobe. The data port always shows the current view, so the value sampled in the strobe cycle is the value before any clear-on-read takes effect. The clear happens on the following edge. A write is a one-cycle enable with a full-width data word, applied on the next edge. Edge-capturing bits set a pending flag. Any pending flag whose mask bit is 1 drives the interrupt, and a read settles the flags again.

Top module: `latch_stat_reg`

## Requirements
- R1: A read-only bit (kind code 0) shows its live input on the read data port in the same cycle, and a write has no effect on it.
- R2: A write-only bit (kind code 1) accepts writes but always reads as 0.
- R3: A stored bit (kind code 2) takes the written value on the edge that samples the write enable and keeps it until the next write.
- R4: A self-clearing bit (kind code 3) that is written with 1 reads 1 for exactly SC_CYCLES cycles after the write edge and then returns to 0 by itself.
- R5: A self-clearing bit returns to 0 on the edge that samples its done input high, even when SC_CYCLES has not elapsed.
- R6: A latch-low bit (kind code 4) reads 0 from the edge after its live input is seen low, and keeps reading 0 after the input recovers until a read. The value shown during the read strobe is the held value.
- R7: On the edge that samples a read strobe, a latch-low bit reloads its live input, so it reads 1 when the input is high and stays 0 when the input is still low.
- R8: A latch-high bit (kind code 5) mirrors R6 and R7 with the opposite polarity: it holds 1 after a high pulse until read, then reloads the live input.
- R9: A transition bit (kind code 6) takes the new live value on the first edge that sees it differ, marks itself pending, and ignores further changes until read.
- R10: On a read edge a transition bit reloads its live input. It stays pending only when the live input differs from the value it held at that read.
- R11: The interrupt output is high whenever a pending transition bit has its mask bit at 1, where a mask bit of 1 enables the bit. A read that leaves no enabled bit pending drops it.
- R12: After the synchronous active-low reset, stored and write-only bits read 0, latch-low bits read 1, latch-high bits read 0, transition bits read the live input, and nothing is pending.
- R13: Writes do not alter latch-low, latch-high or transition bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| live_in | input | WIDTH | Live status signals, one per bit position |
| wr_en | input | 1 | One-cycle write enable |
| wr_data | input | WIDTH | Write data word |
| sc_done | input | WIDTH | Per-bit completion pulse for self-clearing bits |
| rd_stb | input | 1 | One-cycle read strobe; clear-on-read applies on the next edge |
| irq_mask | input | WIDTH | Interrupt enable per bit, 1 = enabled |
| rd_data | output | WIDTH | Current view of the register |
| irq | output | 1 | Interrupt request |

## Verification
The latch bits are driven with single-cycle pulses that return before any read. This separates a bit that holds the event from one that only follows the live input. Reads are also issued while the live input is still asserted, which tells a reload-from-live apart from a fixed reset value on read. The transition bit gets a change followed by a reversal before the read. That shows the first captured value is kept, and that a read which finds the input changed leaves the bit pending. Self-clearing bits run once to their timeout and once with an early done pulse, so the two clearing paths are checked apart. The mask is also changed while a disabled bit is pending, to show that the interrupt gating is combinational.

// File: rtl/stat_reg_pkg.sv
// Package: shared kind codes for the mixed-access status register.
// Assumes: every bit position is described by one 3-bit code in a packed
// parameter, bit i at [3*i +: 3].
package stat_reg_pkg;

    typedef enum logic [2:0] {
        ACC_RO   = 3'd0,
        ACC_WO   = 3'd1,
        ACC_RW   = 3'd2,
        ACC_RWSC = 3'd3,
        ACC_LL   = 3'd4,
        ACC_LH   = 3'd5,
        ACC_LT   = 3'd6
    } acc_kind_e;

    localparam int KIND_W = 3;

    // True for the kinds that hold an event until read.
    function automatic logic is_event_kind(input logic [2:0] k);
        return (k == ACC_LL) || (k == ACC_LH) || (k == ACC_LT);
    endfunction

endpackage

// File: rtl/stat_ctrl_cell.sv
// Module: one plain-access bit (read-only, write-only, stored, self-clearing).
// Assumes: KIND is one of ACC_RO, ACC_WO, ACC_RW, ACC_RWSC; SC_CYCLES >= 1.
// A write always wins over a self-clear in the same cycle.
module stat_ctrl_cell
    import stat_reg_pkg::*;
#(
    parameter logic [2:0] KIND      = ACC_RW,
    parameter int         SC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live_i,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic done_i,
    output logic view_o
);

    localparam int            CNT_W = $clog2(SC_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SC_CYCLES - 1);
    localparam logic          SELF_CLEAR = (KIND == ACC_RWSC);

    logic             stored_q;
    logic [CNT_W-1:0] age_q;

    // Stored value and self-clear age counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_q <= 1'b0;
            age_q    <= '0;
        end else if (wr_en) begin
            stored_q <= wr_bit;
            age_q    <= '0;
        end else if (SELF_CLEAR && stored_q) begin
            if (done_i || (age_q == LAST)) begin
                stored_q <= 1'b0;
                age_q    <= '0;
            end else begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    // Read view per kind.
    always_comb begin
        case (KIND)
            ACC_RO:  view_o = live_i;
            ACC_WO:  view_o = 1'b0;
            default: view_o = stored_q;
        endcase
    end

endmodule

// File: rtl/stat_latch_cell.sv
// Module: one event-holding bit (latch-low, latch-high, latch-on-transition).
// Assumes: KIND is one of ACC_LL, ACC_LH, ACC_LT. A read reloads the live
// value on the edge after the strobe; an event seen in the read cycle is kept.
module stat_latch_cell
    import stat_reg_pkg::*;
#(
    parameter logic [2:0] KIND = ACC_LT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live_i,
    input  logic rd_stb,
    output logic view_o,
    output logic pend_o
);

    logic held_q;
    logic pend_q;

    // Held value and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            case (KIND)
                ACC_LL:  held_q <= 1'b1;
                ACC_LH:  held_q <= 1'b0;
                default: held_q <= live_i;
            endcase
            pend_q <= 1'b0;
        end else if (rd_stb) begin
            held_q <= live_i;
            pend_q <= (KIND == ACC_LT) && (live_i != held_q);
        end else begin
            case (KIND)
                ACC_LL: held_q <= held_q & live_i;
                ACC_LH: held_q <= held_q | live_i;
                default: begin
                    if (!pend_q && (live_i != held_q)) begin
                        held_q <= live_i;
                        pend_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs.
    assign view_o = held_q;
    assign pend_o = pend_q;

endmodule

// File: rtl/stat_irq_reduce.sv
// Module: interrupt reduction of pending flags under an enable mask.
// Assumes: mask bit 1 enables the matching pending flag.
module stat_irq_reduce #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] pend_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic             irq_o
);

    // OR of enabled pending flags.
    always_comb begin
        irq_o = |(pend_i & mask_i);
    end

endmodule

// File: rtl/latch_stat_reg.sv
// Module: mixed-access status register, top level.
// Assumes: BIT_TYPES holds one 3-bit kind code per bit, bit i at [3*i +: 3];
// rd_stb and wr_en are single-cycle strobes from the management logic.
module latch_stat_reg
    import stat_reg_pkg::*;
#(
    parameter int                 WIDTH     = 16,
    parameter int                 SC_CYCLES = 4,
    parameter logic [WIDTH*3-1:0] BIT_TYPES = {
        3'd6, 3'd6, 3'd6, 3'd6,
        3'd5, 3'd5, 3'd4, 3'd4,
        3'd0, 3'd0, 3'd1, 3'd1,
        3'd3, 3'd3, 3'd2, 3'd2}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] live_in,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] sc_done,
    input  logic             rd_stb,
    input  logic [WIDTH-1:0] irq_mask,
    output logic [WIDTH-1:0] rd_data,
    output logic             irq
);

    logic [WIDTH-1:0] view_w;
    logic [WIDTH-1:0] pend_w;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam logic [2:0] KIND = BIT_TYPES[KIND_W*i +: KIND_W];
        if (is_event_kind(KIND)) begin : g_event
            stat_latch_cell #(
                .KIND (KIND)
            ) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .live_i (live_in[i]),
                .rd_stb (rd_stb),
                .view_o (view_w[i]),
                .pend_o (pend_w[i])
            );
        end else begin : g_plain
            stat_ctrl_cell #(
                .KIND      (KIND),
                .SC_CYCLES (SC_CYCLES)
            ) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .live_i (live_in[i]),
                .wr_en  (wr_en),
                .wr_bit (wr_data[i]),
                .done_i (sc_done[i]),
                .view_o (view_w[i])
            );
            assign pend_w[i] = 1'b0;
        end
    end

    stat_irq_reduce #(
        .WIDTH (WIDTH)
    ) u_irq (
        .pend_i (pend_w),
        .mask_i (irq_mask),
        .irq_o  (irq)
    );

    assign rd_data = view_w;

endmodule

// File: rtl/latch_stat_reg_chk.sv
// Module: property checker for latch_stat_reg, bound to every instance.
// Assumes: same parameters as the bound instance; sees ports only.
module latch_stat_reg_chk
    import stat_reg_pkg::*;
#(
    parameter int                 WIDTH     = 16,
    parameter logic [WIDTH*3-1:0] BIT_TYPES = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] live_in,
    input logic             wr_en,
    input logic             rd_stb,
    input logic [WIDTH-1:0] irq_mask,
    input logic [WIDTH-1:0] rd_data,
    input logic             irq
);

    // R11: interrupt needs at least one enabled mask bit.
    p_irq_needs_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|irq_mask));

    // R11: without a read, an interrupt stays until the mask changes.
    p_irq_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_stb) |=> (irq || (irq_mask != $past(irq_mask))));

    for (genvar i = 0; i < WIDTH; i++) begin : g_bitchk
        localparam logic [2:0] KIND = BIT_TYPES[KIND_W*i +: KIND_W];
        if (KIND == ACC_LL) begin : g_ll
            // R6: low input without read gives 0 next cycle.
            p_ll_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!rd_stb && !live_in[i]) |=> !rd_data[i]);
            // R6: a held 0 stays without a read.
            p_ll_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (!rd_stb && !rd_data[i]) |=> !rd_data[i]);
        end else if (KIND == ACC_LH) begin : g_lh
            // R8: high input without read gives 1 next cycle.
            p_lh_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!rd_stb && live_in[i]) |=> rd_data[i]);
            // R8: a held 1 stays without a read.
            p_lh_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!rd_stb && rd_data[i]) |=> rd_data[i]);
        end else if (KIND == ACC_RW) begin : g_rw
            // R3: no write, no change.
            p_rw_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(rd_data[i]));
        end else if (KIND == ACC_RWSC) begin : g_sc
            // R4: a cleared self-clearing bit only sets by a write.
            p_sc_noset_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_en && !rd_data[i]) |=> !rd_data[i]);
        end
    end

endmodule

bind latch_stat_reg latch_stat_reg_chk #(
    .WIDTH     (WIDTH),
    .BIT_TYPES (BIT_TYPES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .live_in  (live_in),
    .wr_en    (wr_en),
    .rd_stb   (rd_stb),
    .irq_mask (irq_mask),
    .rd_data  (rd_data),
    .irq      (irq)
);

// File: tb/sim_latch_stat_reg.sv
// Bench: directed tests for latch_stat_reg with the default bit map:
// bits 0-1 stored, 2-3 self-clearing, 4-5 write-only, 6-7 read-only,
// 8-9 latch-low, 10-11 latch-high, 12-15 transition. SC_CYCLES = 4.
module sim_latch_stat_reg;

    localparam int CLK_PERIOD = 10;
    localparam int SC         = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] live_in;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] sc_done;
    logic        rd_stb;
    logic [15:0] irq_mask;
    logic [15:0] rd_data;
    logic        irq;

    int checks   = 0;
    int failures = 0;

    latch_stat_reg #(.SC_CYCLES(SC)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .live_in  (live_in),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sc_done  (sc_done),
        .rd_stb   (rd_stb),
        .irq_mask (irq_mask),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Compare selected bits of the read data.
    task automatic chk_bits(input string req, input logic [15:0] sel,
                            input logic [15:0] exp);
        checks++;
        if ((rd_data & sel) !== (exp & sel)) begin
            failures++;
            $display("FAIL %s rd_data actual=%h expected=%h", req,
                     rd_data & sel, exp & sel);
        end
    endtask

    task automatic chk_irq(input string req, input logic exp);
        checks++;
        if (irq !== exp) begin
            failures++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
        end
    endtask

    // One clock: through the rising edge to the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        step();
        rd_stb = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        irq_mask = 16'hFFFF;
        #1;
        chk_bits("R12", 16'hFFFF, 16'h5300);
        chk_irq("R12", 1'b0);
        irq_mask = 16'h0000;
    endtask

    task automatic t_ro_and_ignore();
        live_in = 16'h5380;
        #1;
        chk_bits("R1", 16'h00C0, 16'h0080);
        do_write(16'hFF40);
        #1;
        chk_bits("R1", 16'h00C0, 16'h0080);
        chk_bits("R13", 16'hFF00, 16'h5300);
        live_in = 16'h5300;
    endtask

    task automatic t_wo();
        do_write(16'h0030);
        #1;
        chk_bits("R2", 16'h0030, 16'h0000);
    endtask

    task automatic t_rw();
        do_write(16'h0002);
        #1;
        chk_bits("R3", 16'h0003, 16'h0002);
        repeat (3) step();
        chk_bits("R3", 16'h0003, 16'h0002);
    endtask

    task automatic t_sc_timeout();
        do_write(16'h0006);
        #1;
        chk_bits("R4", 16'h000F, 16'h0006);
        repeat (SC - 1) step();
        chk_bits("R4", 16'h000F, 16'h0006);
        step();
        chk_bits("R4", 16'h000F, 16'h0002);
    endtask

    task automatic t_sc_done();
        do_write(16'h000A);
        #1;
        chk_bits("R5", 16'h000F, 16'h000A);
        step();
        sc_done = 16'h0008;
        step();
        sc_done = 16'h0000;
        chk_bits("R5", 16'h000F, 16'h0002);
    endtask

    task automatic t_latch_low();
        live_in = 16'h5200;
        step();
        live_in = 16'h5300;
        #1;
        chk_bits("R6", 16'h0100, 16'h0000);
        step();
        chk_bits("R6", 16'h0100, 16'h0000);
        rd_stb = 1'b1;
        #1;
        chk_bits("R6", 16'h0100, 16'h0000);
        step();
        rd_stb = 1'b0;
        chk_bits("R7", 16'h0300, 16'h0300);
        live_in = 16'h5200;
        step();
        do_read();
        chk_bits("R7", 16'h0100, 16'h0000);
        live_in = 16'h5300;
        step();
        chk_bits("R7", 16'h0100, 16'h0000);
        do_read();
        chk_bits("R7", 16'h0100, 16'h0100);
    endtask

    task automatic t_latch_high();
        live_in = 16'h5700;
        step();
        live_in = 16'h5300;
        step();
        chk_bits("R8", 16'h0C00, 16'h0400);
        do_read();
        chk_bits("R8", 16'h0C00, 16'h0000);
    endtask

    task automatic t_transition();
        irq_mask = 16'h1000;
        live_in  = 16'h4300;
        step();
        live_in = 16'h5300;
        #1;
        chk_bits("R9", 16'h1000, 16'h0000);
        chk_irq("R11", 1'b1);
        step();
        chk_bits("R9", 16'h1000, 16'h0000);
        rd_stb = 1'b1;
        #1;
        chk_bits("R10", 16'h1000, 16'h0000);
        step();
        rd_stb = 1'b0;
        #1;
        chk_bits("R10", 16'h1000, 16'h1000);
        chk_irq("R10", 1'b1);
        do_read();
        chk_irq("R11", 1'b0);
        live_in = 16'h7300;
        step();
        chk_bits("R9", 16'hF000, 16'h7000);
        chk_irq("R11", 1'b0);
        irq_mask = 16'h3000;
        #1;
        chk_irq("R11", 1'b1);
        do_read();
        chk_irq("R11", 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        live_in  = 16'h5300;
        wr_en    = 1'b0;
        wr_data  = '0;
        sc_done  = '0;
        rd_stb   = 1'b0;
        irq_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ro_and_ignore();
        t_wo();
        t_rw();
        t_sc_timeout();
        t_sc_done();
        t_latch_low();
        t_latch_high();
        t_transition();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule